// File: doc/BRIEF.md
# Relocatable Four-Pin GPIO Window

This peripheral gives a small processor core four general-purpose pins through a two-byte register window. The window's location comes from a 32-bit base register that the core writes through a control-register port. The base may be any value, including odd and high addresses beyond the RAM range. A base of zero turns the window off. The first window byte selects the direction of each pin. The second byte reads pin levels and drives output levels.

The core issues byte accesses on a simple request bus. An access that falls inside the window is answered by the peripheral, which raises `bus_hit`. Any other access is handed to the memory side on `mem_req`, and the peripheral's read data stays zero. The block also emits one-cycle invalidate pulses that carry an address, aimed at the core's load-reserved tracker. A pulse follows each move of the window. A pulse also follows each level change on an input pin. Software can therefore reserve the data byte, sleep, and wake when an input moves.

Top module: `gpio_window`

## Requirements
- R1: During and after reset all pins are inputs, stored output bits are 0, `pin_out` is 0, the base register is 0 and `inval_valid` is low.
- R2: While the base is 0, no access hits, `mem_req` equals `bus_req`, and input pin changes produce no invalidate pulse.
- R3: With base B non-zero, an access at B (any alignment, including addresses near 2^32) hits the direction byte, and an access at B+1 hits the data byte. In the direction byte, bit 0 is pin a, bit 1 is pin b, bit 2 is pin c and bit 3 is pin d, and 1 means output. Bits 7..4 read as 0.
- R4: A read of the data byte returns, for each output pin, its stored bit and, for each input pin, the pin level after a two-flop synchronizer. The bit positions are the same as in R3.
- R5: A write to the data byte updates only the bits of output pins, and writes to input bits are ignored. `pin_out` equals direction AND stored data, and it follows a write on the next clock.
- R6: A direction write that turns a pin from output to input drives that pin low and loads its stored bit from the synchronized pin level.
- R7: A direction write that turns a pin from input to output drives it at once with its stored bit, which while the pin was an input follows its synchronized level.
- R8: A base write pulses an invalidate carrying the old base (if non-zero) in the cycle after the write, then one carrying the new base (if non-zero) in the following cycle. Each pulse lasts one cycle.
- R9: With the window enabled, a level change on an input pin produces one invalidate pulse carrying B+1, three clocks after the pin changes. Changes on output pins produce none.
- R10: An access outside the window raises `mem_req`, leaves `bus_hit` low, returns read data 0 and changes no peripheral state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Byte access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero unless a window read |
| bus_hit | output | 1 | Access served by the window |
| mem_req | output | 1 | Access forwarded to memory |
| csr_we | input | 1 | Base register write strobe |
| csr_wdata | input | 32 | New base value |
| csr_rdata | output | 32 | Current base value |
| pin_in | input | 4 | Pin levels, asynchronous |
| pin_out | output | 4 | Driven pin levels |
| inval_valid | output | 1 | Reservation invalidate pulse |
| inval_addr | output | 32 | Address invalidated by the pulse |

## Verification
A wrong direction bit shows up on `pin_out` one clock after the write that set it. It also shows on the next read of either window byte, because input bits then return the pin level instead of the stored value. A missed or duplicated invalidate appears on `inval_valid` within three clocks of its cause. The base move case fixes the exact order of the old-address pulse and the new-address pulse. A wrong base value shows up as a decode error: the next access to the old or new window either hits when it should forward to memory, or forwards when it should hit.

// File: rtl/gpio_window_pkg.sv
package gpio_window_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_OLD  = 2'd1,
    SRC_NEW  = 2'd2,
    SRC_PIN  = 2'd3
  } inval_src_e;

  // {hit on data byte, hit on direction byte}
  function automatic logic [1:0] window_decode(input logic [ADDR_W-1:0] addr,
                                               input logic [ADDR_W-1:0] base);
    logic en;
    en = (base != '0);
    return {en && (addr == base + 1'b1), en && (addr == base)};
  endfunction

  // Output pins show the stored bit, input pins show the synchronized level.
  function automatic logic [BYTE_W-1:0] data_view(input logic [BYTE_W-1:0] dir,
                                                  input logic [BYTE_W-1:0] data,
                                                  input logic [BYTE_W-1:0] pins);
    return (dir & data) | (~dir & pins);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] pin_sync,
  output logic [W-1:0] pin_change
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= pin_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign pin_sync   = chain[STAGES-1];
  assign pin_change = chain[STAGES-1] ^ prev_q;
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         data_we,
  input  logic [W-1:0] wr_bits,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] data_q,
  output logic [W-1:0] pin_out
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic dir_r;
    logic dat_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_r <= 1'b0;
        dat_r <= 1'b0;
      end else if (dir_we) begin
        dir_r <= wr_bits[i];
        // a pin becoming (or staying) an input takes the pin level
        if (!wr_bits[i]) dat_r <= pin_sync[i];
      end else if (dir_r) begin
        if (data_we) dat_r <= wr_bits[i];
      end else begin
        // inputs keep tracking the pin, so a later switch to output drives it
        dat_r <= pin_sync[i];
      end
    end

    assign dir_q[i]   = dir_r;
    assign data_q[i]  = dat_r;
    assign pin_out[i] = dir_r & dat_r;
  end
endmodule

// File: rtl/gpio_inval_queue.sv
module gpio_inval_queue
  import gpio_window_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] base_old,
  input  logic [ADDR_W-1:0] base_new,
  input  logic              pin_evt,
  input  logic [ADDR_W-1:0] pin_addr,
  output logic              inval_valid,
  output logic [ADDR_W-1:0] inval_addr
);
  logic              old_v, new_v, pin_v;
  logic [ADDR_W-1:0] old_a, new_a, pin_a;
  inval_src_e        src;

  always_comb begin
    if (old_v)      src = SRC_OLD;
    else if (new_v) src = SRC_NEW;
    else if (pin_v) src = SRC_PIN;
    else            src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_OLD: inval_addr = old_a;
      SRC_NEW: inval_addr = new_a;
      SRC_PIN: inval_addr = pin_a;
      default: inval_addr = '0;
    endcase
  end
  assign inval_valid = (src != SRC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      old_v <= 1'b0;
      new_v <= 1'b0;
      old_a <= '0;
      new_a <= '0;
    end else if (csr_we) begin
      old_v <= (base_old != '0);
      old_a <= base_old;
      new_v <= (base_new != '0);
      new_a <= base_new;
    end else begin
      if (src == SRC_OLD) old_v <= 1'b0;
      if (src == SRC_NEW) new_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_v <= 1'b0;
      pin_a <= '0;
    end else if (pin_evt) begin
      pin_v <= 1'b1;
      pin_a <= pin_addr;
    end else if (src == SRC_PIN) begin
      pin_v <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_window.sv
module gpio_window
  import gpio_window_pkg::*;
#(
  parameter int unsigned NPINS       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_hit,
  output logic              mem_req,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_wdata,
  output logic [ADDR_W-1:0] csr_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic              inval_valid,
  output logic [ADDR_W-1:0] inval_addr
);
  localparam int unsigned PAD_W = BYTE_W - NPINS;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        hit_vec;
  logic              hit_dir, hit_dat, win_hit;
  logic              dir_we, data_we;
  logic [NPINS-1:0]  pin_sync, pin_change, dir_q, data_q;
  logic              pin_evt;
  logic [ADDR_W-1:0] pin_evt_addr;
  logic [BYTE_W-1:0] dir_byte, dat_byte;

  always_ff @(posedge clk) begin
    if (!rst_n)      base_q <= '0;
    else if (csr_we) base_q <= csr_wdata;
  end
  assign csr_rdata = base_q;

  assign hit_vec = window_decode(bus_addr, base_q);
  assign hit_dir = hit_vec[0];
  assign hit_dat = hit_vec[1];
  assign win_hit = bus_req && (hit_dir || hit_dat);
  assign bus_hit = win_hit;
  assign mem_req = bus_req && !(hit_dir || hit_dat);
  assign dir_we  = bus_req && bus_wr && hit_dir;
  assign data_we = bus_req && bus_wr && hit_dat;

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_async  (pin_in),
    .pin_sync   (pin_sync),
    .pin_change (pin_change)
  );

  gpio_pin_bank #(.W(NPINS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_we   (dir_we),
    .data_we  (data_we),
    .wr_bits  (bus_wdata[NPINS-1:0]),
    .pin_sync (pin_sync),
    .dir_q    (dir_q),
    .data_q   (data_q),
    .pin_out  (pin_out)
  );

  assign dir_byte = {{PAD_W{1'b0}}, dir_q};
  assign dat_byte = data_view(dir_byte, {{PAD_W{1'b0}}, data_q},
                              {{PAD_W{1'b0}}, pin_sync});

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_wr) begin
      if (hit_dir)      bus_rdata = dir_byte;
      else if (hit_dat) bus_rdata = dat_byte;
    end
  end

  assign pin_evt      = (base_q != '0) && |(pin_change & ~dir_q);
  assign pin_evt_addr = base_q + 1'b1;

  gpio_inval_queue u_inval (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_we      (csr_we),
    .base_old    (base_q),
    .base_new    (csr_wdata),
    .pin_evt     (pin_evt),
    .pin_addr    (pin_evt_addr),
    .inval_valid (inval_valid),
    .inval_addr  (inval_addr)
  );
endmodule

// File: rtl/gpio_window_chk.sv
module gpio_window_chk #(
  parameter int unsigned NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_hit,
  input logic             mem_req,
  input logic [7:0]       bus_rdata,
  input logic             csr_we,
  input logic [31:0]      csr_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] dir_q,
  input logic             inval_valid,
  input logic [31:0]      inval_addr
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0) && (csr_rdata == '0) && !inval_valid);

  assert_base_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata == '0) |-> !bus_hit && (mem_req == bus_req));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:NPINS] == '0);

  assert_out_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~dir_q) == '0);

  assert_old_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_rdata != '0) |=> inval_valid && (inval_addr == $past(csr_rdata)));

  assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> (bus_rdata == '0) && (mem_req == bus_req));
endmodule

bind gpio_window gpio_window_chk #(.NPINS(NPINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_hit     (bus_hit),
  .mem_req     (mem_req),
  .bus_rdata   (bus_rdata),
  .csr_we      (csr_we),
  .csr_rdata   (csr_rdata),
  .pin_out     (pin_out),
  .dir_q       (dir_q),
  .inval_valid (inval_valid),
  .inval_addr  (inval_addr)
);

// File: tb/gpio_window_bench.sv
module gpio_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_hit, mem_req;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [3:0]  pin_in = '0;
  logic [3:0]  pin_out;
  logic        inval_valid;
  logic [31:0] inval_addr;

  int checks = 0, errors = 0;
  int cyc = 0;
  int log_n = 0;
  logic [31:0] log_addr [16];
  int          log_cyc  [16];
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_window u_gpio_window (.*);

  always @(negedge clk) if (inval_valid && log_n < 16) begin
    log_addr[log_n] = inval_addr;
    log_cyc[log_n]  = cyc;
    log_n++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [7:0] d,
                           output logic h, output logic m);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    #1; h = bus_hit; m = mem_req;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [7:0] d,
                          output logic h, output logic m);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = a;
    #1; d = bus_rdata; h = bus_hit; m = mem_req;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic csr_write(input logic [31:0] v);
    @(negedge clk);
    #1 log_n = 0;
    csr_we = 1; csr_wdata = v;
    @(negedge clk);
    csr_we = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_pins(input logic [3:0] p, output int c0);
    @(negedge clk);
    #1 log_n = 0;
    pin_in = p; c0 = cyc;
    repeat (6) @(negedge clk);
  endtask

  // {write, signed offset from base, wdata, expected rdata, expected hit, expected pin_out}
  localparam int NV = 13;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'hF3, 8'h00, 1'b1, 4'b0010},  // R7 a,b become outputs; R3 upper bits dropped
    {1'b0, 8'h00, 8'h00, 8'h03, 1'b1, 4'b0010},  // R3
    {1'b1, 8'h01, 8'hFD, 8'h00, 1'b1, 4'b0001},  // R5
    {1'b0, 8'h01, 8'h00, 8'h09, 1'b1, 4'b0001},  // R4
    {1'b0, 8'h02, 8'h00, 8'h00, 1'b0, 4'b0001},  // R10
    {1'b1, 8'hFF, 8'h55, 8'h00, 1'b0, 4'b0001},  // R10
    {1'b0, 8'h01, 8'h00, 8'h09, 1'b1, 4'b0001},  // R10 no state change
    {1'b1, 8'h00, 8'h0C, 8'h00, 1'b1, 4'b1000},  // R6 and R7
    {1'b0, 8'h01, 8'h00, 8'h0A, 1'b1, 4'b1000},  // R4
    {1'b1, 8'h01, 8'h04, 8'h00, 1'b1, 4'b0100},  // R5
    {1'b0, 8'h01, 8'h00, 8'h06, 1'b1, 4'b0100},  // R4
    {1'b1, 8'h01, 8'h03, 8'h00, 1'b1, 4'b0000},  // R5 input bits ignored
    {1'b0, 8'h01, 8'h00, 8'h02, 1'b1, 4'b0000}   // R5
  };

  localparam logic [31:0] BASE = 32'h0001_2345;
  localparam logic [31:0] HIGH = 32'hFFFF_FFF0;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic h, m;
    int c0;

    repeat (3) @(negedge clk);
    check(pin_out == 0 && csr_rdata == 0 && !inval_valid, "R1", "reset state",
          {pin_out, csr_rdata[27:0]}, 0);
    rst_n = 1;
    @(negedge clk);
    check(pin_out == 0 && csr_rdata == 0 && !inval_valid, "R1", "after reset",
          {pin_out, csr_rdata[27:0]}, 0);

    // R2 window disabled
    bus_read(32'h0, d, h, m);
    check(!h && m && d == 0, "R2", "base zero read", {d, 3'b0, h, 3'b0, m}, 32'h0001);
    set_pins(4'b0100, c0);
    check(log_n == 0, "R2", "no inval while disabled", log_n, 0);

    // R8 first move: old base zero so only the new one
    csr_write(BASE);
    check(log_n == 1 && log_addr[0] == BASE, "R8", "enable pulse", log_addr[0], BASE);

    // R9 input change with window enabled
    set_pins(4'b1010, c0);
    check(log_n == 1 && log_addr[0] == BASE + 1, "R9", "pin change inval addr",
          log_addr[0], BASE + 1);
    check(log_n == 1 && log_cyc[0] - c0 == 3, "R9", "pin change latency",
          log_cyc[0] - c0, 3);
    bus_read(BASE + 1, d, h, m);
    check(d == 8'h0A && h && !m, "R4", "all-input read", d, 8'h0A);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      logic [31:0] a;
      v = VEC[i];
      a = BASE + {{24{v[28]}}, v[28:21]};
      if (v[29]) bus_write(a, v[20:13], h, m);
      else       bus_read(a, d, h, m);
      check(h == v[4] && m == !v[4], v[4] ? "R3" : "R10", $sformatf("vec %0d hit", i),
            {h, m}, {v[4], !v[4]});
      if (!v[29]) check(d == v[12:5], "R4", $sformatf("vec %0d rdata", i), d, v[12:5]);
      check(pin_out == v[3:0], "R5", $sformatf("vec %0d pin_out", i), pin_out, v[3:0]);
    end

    // R9 change on output pin d: no pulse, output bit unchanged
    set_pins(4'b0010, c0);
    check(log_n == 0, "R9", "output pin change ignored", log_n, 0);
    bus_read(BASE + 1, d, h, m);
    check(d == 8'h02, "R4", "output bit keeps stored value", d, 8'h02);

    set_pins(4'b0011, c0);
    check(log_n == 1 && log_addr[0] == BASE + 1, "R9", "input pin a change",
          log_addr[0], BASE + 1);
    bus_read(BASE + 1, d, h, m);
    check(d == 8'h03, "R4", "live input a", d, 8'h03);

    // R8 move to high address: old then new, consecutive cycles
    csr_write(HIGH);
    check(log_n == 2 && log_addr[0] == BASE && log_addr[1] == HIGH, "R8", "move order",
          log_addr[1], HIGH);
    check(log_n == 2 && log_cyc[1] - log_cyc[0] == 1, "R8", "one cycle each",
          log_cyc[1] - log_cyc[0], 1);
    bus_read(HIGH + 1, d, h, m);
    check(h && d == 8'h03, "R3", "high window read", d, 8'h03);
    bus_read(BASE + 1, d, h, m);
    check(!h && m && d == 0, "R10", "old window misses", {h, m, d}, 32'h100);

    // R8 disable: only the old pulse
    csr_write(32'h0);
    check(log_n == 1 && log_addr[0] == HIGH, "R8", "disable pulse", log_addr[0], HIGH);
    bus_read(HIGH + 1, d, h, m);
    check(!h && m && d == 0, "R2", "disabled window misses", {h, m, d}, 32'h100);
    set_pins(4'b0001, c0);
    check(log_n == 0, "R2", "no inval after disable", log_n, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule